// File: doc/BRIEF.md
# Toggle-Acknowledged Global Error Register

This block keeps a global error register beside an acknowledge register that software owns. An error bit is active (pending) whenever the two registers hold different values for that bit. Error sources raise faults by presenting a bit mask with a strobe. Only the requested bits that are not already pending are flipped in the error register, so a source never clears an error by raising it a second time. Software clears an error by writing the acknowledge register so that the bit matches the error register again.

Each request that flips at least one bit produces a one-cycle interrupt pulse when the global interrupt enable is high. One bit position is reserved for the command-queue fault. Its pending state is driven out as a status level. An acknowledge that clears that bit while it is pending produces a one-cycle resume pulse for the command-queue consumer. The error, acknowledge and pending vectors can all be read through a 32-bit register port, and reads have no side effects.

Top module: `fault_toggle_reg`

## Requirements
- R1: After reset the error register, the acknowledge register and the pending vector all read zero, and both pulse outputs are low.
- R2: Reading address 2 returns the pending vector, which is the bitwise XOR of the error register and the acknowledge register. Bits above ERR_W read zero on every address.
- R3: A request with `err_req_vld` high flips each requested bit that is not pending. The result can be read at address 0 from the next cycle on.
- R4: A requested bit that is already pending is left unchanged in the error register.
- R5: `irq_pulse` is high for the one cycle after a request that flipped at least one bit, and only if `irq_en` was high in the request cycle. In every other cycle it is low.
- R6: A write to address 1 stores the low ERR_W bits of the write data into the acknowledge register in full. This includes bits that were not pending, which then become pending. Reads of address 1 return the stored value.
- R7: Writes to address 0, 2 or 3 have no effect on either register.
- R8: `cmdq_err` is high exactly when bit CMDQ_BIT (default 0) of the pending vector is set.
- R9: `cmdq_resume` is high for one cycle after an acknowledge write that flips bit CMDQ_BIT while that bit was pending. Otherwise it is low.
- R10: A request and an acknowledge write in the same cycle are both applied, and the request's pending test uses the values held before that cycle.
- R11: Reads at any address leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 error, 1 acknowledge, 2 pending, 3 reads zero |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| err_req_vld | input | 1 | Error request strobe |
| err_req_mask | input | ERR_W (8) | Bits requested to become pending |
| irq_en | input | 1 | Global error interrupt enable |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| cmdq_err | output | 1 | Command-queue error bit pending |
| cmdq_resume | output | 1 | One-cycle pulse telling the command queue to resume |

## Verification
All three vectors can be read in the same cycle they are selected, so a wrong bit in either register shows on `reg_rdata` in the first cycle the bench selects that address after the bad update. The bench rotates the address every cycle, so such a bit appears within three cycles. A request or acknowledge that takes its pending test from the wrong cycle shows up as a missing or extra pulse on `irq_pulse` or `cmdq_resume` in the very next cycle. It also leaves a flipped bit that `cmdq_err` or the pending read exposes.

// File: rtl/fte_pkg.sv
package fte_pkg;
  localparam logic [1:0] SEL_ERR  = 2'd0;
  localparam logic [1:0] SEL_ACK  = 2'd1;
  localparam logic [1:0] SEL_PEND = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;
endpackage

// File: rtl/fte_rst_sync.sv
module fte_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= '0;
        else          sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= '0;
        else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/fte_err_bank.sv
module fte_err_bank #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld_i,
  input  logic [ERR_W-1:0] req_mask_i,
  input  logic [ERR_W-1:0] pend_i,
  output logic [ERR_W-1:0] new_bits_o,
  output logic [ERR_W-1:0] err_q
);
  logic [ERR_W-1:0] err_d;
  logic             err_en;

  always_comb begin
    new_bits_o = req_vld_i ? (req_mask_i & ~pend_i) : '0;
    err_en     = |new_bits_o;
    err_d      = err_q ^ new_bits_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld_i |=> $stable(err_q));
  // R4
  err_no_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_i |=> ((err_q ^ $past(err_q)) & $past(pend_i)) == '0);
endmodule

// File: rtl/fte_ack_bank.sv
module fte_ack_bank #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [ERR_W-1:0] wdata_i,
  output logic [ERR_W-1:0] ack_q
);
  logic [ERR_W-1:0] ack_d;

  always_comb ack_d = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ack_q <= '0;
    else if (wr_en_i) ack_q <= ack_d;
  end

  // R11
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ack_q));
endmodule

// File: rtl/fte_notify.sv
module fte_notify #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld_i,
  input  logic             irq_en_i,
  input  logic [ERR_W-1:0] new_bits_i,
  input  logic             ack_wr_i,
  input  logic             ack_old_c_i,
  input  logic             ack_new_c_i,
  input  logic             pend_c_i,
  output logic             irq_pulse_o,
  output logic             resume_o
);
  logic irq_d, res_d;

  always_comb begin
    irq_d = req_vld_i & irq_en_i & (|new_bits_i);
    res_d = ack_wr_i & pend_c_i & (ack_old_c_i ^ ack_new_c_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse_o <= 1'b0;
      resume_o    <= 1'b0;
    end else begin
      irq_pulse_o <= irq_d;
      resume_o    <= res_d;
    end
  end

  // R5
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> ($past(irq_en_i) && $past(req_vld_i)));
  // R9
  resume_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> ($past(pend_c_i) && $past(ack_wr_i)));
endmodule

// File: rtl/fault_toggle_reg.sv
module fault_toggle_reg #(
  parameter int ERR_W       = 8,
  parameter int DATA_W      = 32,
  parameter int CMDQ_BIT    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              err_req_vld,
  input  logic [ERR_W-1:0]  err_req_mask,
  input  logic              irq_en,
  output logic              irq_pulse,
  output logic              cmdq_err,
  output logic              cmdq_resume
);
  import fte_pkg::*;

  localparam int PAD_W = DATA_W - ERR_W;

  logic             rst_n_s;
  logic [ERR_W-1:0] err_q, ack_q, pend, new_bits, ack_wdata, rd_sel;
  logic             ack_wr;

  fte_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  always_comb begin
    pend      = err_q ^ ack_q;
    ack_wr    = reg_wr && (reg_addr == SEL_ACK);
    ack_wdata = reg_wdata[ERR_W-1:0];
  end

  fte_err_bank #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n_s), .req_vld_i(err_req_vld),
    .req_mask_i(err_req_mask), .pend_i(pend),
    .new_bits_o(new_bits), .err_q(err_q));

  fte_ack_bank #(.ERR_W(ERR_W)) u_ack (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(ack_wr),
    .wdata_i(ack_wdata), .ack_q(ack_q));

  fte_notify #(.ERR_W(ERR_W)) u_ntf (
    .clk(clk), .rst_n(rst_n_s), .req_vld_i(err_req_vld),
    .irq_en_i(irq_en), .new_bits_i(new_bits), .ack_wr_i(ack_wr),
    .ack_old_c_i(ack_q[CMDQ_BIT]), .ack_new_c_i(ack_wdata[CMDQ_BIT]),
    .pend_c_i(pend[CMDQ_BIT]), .irq_pulse_o(irq_pulse),
    .resume_o(cmdq_resume));

  always_comb begin
    case (reg_addr)
      SEL_ERR:  rd_sel = err_q;
      SEL_ACK:  rd_sel = ack_q;
      SEL_PEND: rd_sel = pend;
      default:  rd_sel = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:ERR_W];
      assign reg_rdata = {{PAD_W{1'b0}}, rd_sel};
    end else begin : g_nopad
      assign reg_rdata = rd_sel;
    end
  endgenerate

  assign cmdq_err = pend[CMDQ_BIT];

  // R7
  err_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!err_req_vld && reg_wr && reg_addr != SEL_ACK) |=> ($stable(err_q) && $stable(ack_q)));
  // R8
  cmdq_status_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmdq_resume) |-> !cmdq_err || $past(err_req_vld));
endmodule

// File: tb/sim_fault_toggle_reg.sv
`timescale 1ns/1ps
module sim_fault_toggle_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_req_vld = 1'b0;
  logic [7:0]  err_req_mask = '0;
  logic        irq_en = 1'b0;
  logic        irq_pulse, cmdq_err, cmdq_resume;

  always #5 clk = ~clk;

  fault_toggle_reg u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_req_vld(err_req_vld),
    .err_req_mask(err_req_mask), .irq_en(irq_en), .irq_pulse(irq_pulse),
    .cmdq_err(cmdq_err), .cmdq_resume(cmdq_resume));

  int checks = 0, fails = 0, cyc = 0;
  bit run = 1'b0;
  string scen = "R1";

  logic [7:0] m_err = '0, m_ack = '0;
  bit m_irq = 0, m_res = 0;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_err = '0; m_ack = '0; m_irq = 0; m_res = 0;
    end else begin
      logic [7:0] p, nb;
      p  = m_err ^ m_ack;
      nb = err_req_vld ? (err_req_mask & ~p) : 8'h00;
      m_irq = err_req_vld && irq_en && (nb != 0);
      m_res = reg_wr && reg_addr == 2'd1 && p[0] && (reg_wdata[0] != m_ack[0]);
      m_err = m_err ^ nb;
      if (reg_wr && reg_addr == 2'd1) m_ack = reg_wdata[7:0];
    end
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual=%h expected=%h", scen, tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      logic [31:0] er;
      case (reg_addr)
        2'd0: er = {24'h0, m_err};
        2'd1: er = {24'h0, m_ack};
        2'd2: er = {24'h0, m_err ^ m_ack};
        default: er = 32'h0;
      endcase
      chk(reg_addr == 2'd0 ? "R3" : reg_addr == 2'd1 ? "R6" : "R2", "rdata", reg_rdata, er);
      chk("R5", "irq_pulse", {31'h0, irq_pulse}, {31'h0, m_irq});
      chk("R8", "cmdq_err", {31'h0, cmdq_err}, {31'h0, m_err[0] ^ m_ack[0]});
      chk("R9", "cmdq_resume", {31'h0, cmdq_resume}, {31'h0, m_res});
    end
  end

  task automatic drive(bit wr, logic [1:0] a, logic [31:0] d, bit v, logic [7:0] m, bit en);
    @(posedge clk); #2;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    err_req_vld = v; err_req_mask = m; irq_en = en;
  endtask

  task automatic idle_reads(int n);
    for (int i = 0; i < n; i++) drive(0, 2'(i % 4), 32'h0, 0, 8'h00, 1);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run = 1'b1;
    scen = "R1";  idle_reads(4);
    scen = "R3";  drive(0, 0, 0, 1, 8'h05, 1); idle_reads(4);
    scen = "R4";  drive(0, 0, 0, 1, 8'h07, 1); idle_reads(4);
                  drive(0, 2, 0, 1, 8'h07, 1); idle_reads(3);
    scen = "R5";  drive(0, 0, 0, 1, 8'h08, 0); idle_reads(4);
    scen = "R6";  drive(1, 1, 32'hFFFF_FF03, 0, 0, 1); idle_reads(4);
                  drive(1, 1, 32'h0000_0083, 0, 0, 1); idle_reads(4);
    scen = "R7";  drive(1, 0, 32'hFF, 0, 0, 1); drive(1, 2, 32'hFF, 0, 0, 1);
                  drive(1, 3, 32'hFF, 0, 0, 1); idle_reads(4);
    scen = "R8";  drive(0, 2, 0, 1, 8'h01, 1); idle_reads(4);
    scen = "R9";  drive(1, 1, {24'h0, m_err}, 0, 0, 1); idle_reads(3);
                  drive(1, 1, {24'h0, m_ack ^ 8'h01}, 0, 0, 1); idle_reads(3);
                  drive(1, 1, {24'h0, m_err}, 0, 0, 1); idle_reads(3);
    scen = "R10"; drive(1, 1, {24'h0, m_ack ^ 8'h30}, 1, 8'h31, 1); idle_reads(4);
    scen = "R11"; idle_reads(12);
    scen = "RND";
    lf = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[3] & lf[9], lf[5:4], {lf[31:16], lf[15:8] ^ lf[23:16]},
            lf[7] & lf[12], lf[27:20], lf[13] | lf[2]);
    end
    idle_reads(4);
    run = 1'b0;
    finish_up();
  end
endmodule